// File: doc/BRIEF.md
# Host-to-Processor Mailbox Status Register

This block is the meeting point between a bus host and the embedded processor of an instrument. The host drops a command word and a parameter word into two holding registers. It reads back a 16-bit status word and a query-response word. The processor raises handshake flags when it can take a new command and when an answer is waiting. A host command write lowers both flags in hardware. The processor also writes a completion flag and an active-low error flag, and reports how its self test and its boot went.

A small device-state machine runs alongside. It walks from hard reset through configuration init, self test and processor boot, and ends in a passed state, a running state or one of two failure states. A soft-reset input sends it back to the start. Two status bits show whether the outbound 32-bit data queue holds any word and whether it holds a full block. They are computed from the queue's fill count. The state is published on its own port as well as through the status word.

Top module: `mbox_status_reg`

## Requirements
- R1: Status bit 0 (command ready) goes to 1 the cycle after a `proc_cmd_rdy_set` pulse. It goes to 0 the cycle after any `host_cmd_wr`. When both arrive in the same cycle, the bit ends at 0.
- R2: Status bit 1 (response ready) goes to 1 the cycle after `proc_resp_load`, and in that same cycle `qresp_word` takes `proc_resp_data`. The bit goes to 0 the cycle after any `host_cmd_wr`. When both arrive in the same cycle, the bit ends at 0.
- R3: A host command write or parameter write puts its data on `cmd_word` or `par_word` one cycle later.
- R4: Status bit 6 (done) and bit 5 (error, active low, 0 = error) change only on `proc_flag_wr`, which loads `proc_done_val` and `proc_err_n_val`. Without that strobe, both values are ignored. After reset, done is 0 and error is 1.
- R5: Status bit 9 (data ready) equals `q_count != 0` in the same cycle. Bit 10 (block ready) equals `q_count >= BLOCK_WORDS` in the same cycle.
- R6: `dev_state` is encoded as 0 hard reset, 1 soft reset, 2 config init, 3 self test, 4 booting, 5 failed, 6 init failed, 7 passed and 8 running. After reset it is 0. The transitions are: 0 or 1 to 2 while `hw_init_ok` is high; 2 to 3 on `cfg_done`; 3 to 5 on `st_fail` (this takes priority), otherwise 3 to 4 on `st_pass`; 4 to 7 on `boot_ok`; 7 to 8 on `init_done`. States 5 and 6 are left only through soft reset.
- R7: If `boot_ok` does not arrive within `BOOT_TIMEOUT` cycles of entering state 4, the state moves to 6 on the `BOOT_TIMEOUT`-th clock edge after entry.
- R8: `soft_rst` moves the state to 1 on the next cycle from any state. In the same cycle it clears command ready, response ready, done, self-test-done and loaded, and sets error to 1.
- R9: Status bit 3 (passed) is 1 only in states 7 and 8.
- R10: Status bit 4 (ready) is 1 in state 2 and in state 8, and 0 in every other state.
- R11: Status bit 8 (self test done) sets on the step from 3 to 4. Bit 7 (loaded) sets on the step from 4 to 7. Bit 2 (hardware OK) is `hw_init_ok` delayed by one register.
- R12: Status bits 15:11 always read 0. Right after reset the status word is 0x0020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_wr | input | 1 | Host write strobe for the command register |
| host_cmd_data | input | DATA_W | Command word |
| host_par_wr | input | 1 | Host write strobe for the parameter register |
| host_par_data | input | DATA_W | Parameter word |
| proc_cmd_rdy_set | input | 1 | Processor pulse: ready for a command |
| proc_resp_load | input | 1 | Processor pulse: load query response |
| proc_resp_data | input | DATA_W | Query response word |
| proc_flag_wr | input | 1 | Processor strobe that loads done and error |
| proc_done_val | input | 1 | Done value to load |
| proc_err_n_val | input | 1 | Active-low error value to load |
| hw_init_ok | input | 1 | Hardware init complete (level) |
| cfg_done | input | 1 | Configuration init complete (pulse) |
| st_pass | input | 1 | Self test passed (pulse) |
| st_fail | input | 1 | Self test failed (pulse) |
| boot_ok | input | 1 | Processor booted with valid model code (pulse) |
| init_done | input | 1 | Processor finished initialization (pulse) |
| soft_rst | input | 1 | Soft reset request (pulse) |
| q_count | input | CNT_W | Outbound queue fill count, in 32-bit words |
| cmd_word | output | DATA_W | Held command word |
| par_word | output | DATA_W | Held parameter word |
| qresp_word | output | DATA_W | Held query response word |
| status_word | output | 16 | Status word, free of side effects |
| dev_state | output | 4 | Device state code |

## Verification
The bound checker watches several rules on every cycle: that a host command write lowers command ready, and that a processor set raises it when nothing collides; that a response load captures its data; that command data is captured; that an empty queue shows no data flags; that soft reset lands in state 1 with the sticky bits cleared; and that the passed and init-failed states are entered only from booting. Other behaviour only the bench's scenarios can show. This covers the exact outcome of a same-cycle set and clear, the block-ready threshold at its edges, the full walk through each state with its ready and passed meanings, the exact cycle on which the boot timeout fires, and that done and error ignore values sent without the strobe.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    ST_HARD  = 4'd0,
    ST_SOFT  = 4'd1,
    ST_CFG   = 4'd2,
    ST_TEST  = 4'd3,
    ST_BOOT  = 4'd4,
    ST_FAIL  = 4'd5,
    ST_IFAIL = 4'd6,
    ST_PASS  = 4'd7,
    ST_RUN   = 4'd8
  } dev_state_e;

  localparam int STAT_W     = 16;
  localparam int B_CMD_RDY  = 0;
  localparam int B_RESP_RDY = 1;
  localparam int B_HW_OK    = 2;
  localparam int B_PASSED   = 3;
  localparam int B_READY    = 4;
  localparam int B_ERR_N    = 5;
  localparam int B_DONE     = 6;
  localparam int B_LOADED   = 7;
  localparam int B_ST_DONE  = 8;
  localparam int B_DATA_RDY = 9;
  localparam int B_BLK_RDY  = 10;

endpackage

// File: rtl/mbox_setclr_flag.sv
// One handshake flag: set by the processor side, cleared by the host side.
// A clear or flush has priority over a set in the same cycle.
module mbox_setclr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic q_o
);

  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i | flush_i;
    q_d  = set_i & ~clr_i & ~flush_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (q_en) begin
      q_o <= q_d;
    end
  end

endmodule

// File: rtl/mbox_handshake.sv
// Command, parameter and response holding registers with their handshake
// flags, and the processor-written done and error flags.
module mbox_handshake #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_cmd_wr,
  input  logic [DATA_W-1:0] host_cmd_data,
  input  logic              host_par_wr,
  input  logic [DATA_W-1:0] host_par_data,
  input  logic              proc_cmd_rdy_set,
  input  logic              proc_resp_load,
  input  logic [DATA_W-1:0] proc_resp_data,
  input  logic              proc_flag_wr,
  input  logic              proc_done_val,
  input  logic              proc_err_n_val,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] par_word,
  output logic [DATA_W-1:0] qresp_word,
  output logic              cmd_rdy,
  output logic              resp_rdy,
  output logic              done,
  output logic              err_n
);

  localparam int NFLAG   = 2;
  localparam int F_CMD   = 0;
  localparam int F_RESP  = 1;

  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_q;

  assign set_vec[F_CMD]  = proc_cmd_rdy_set;
  assign set_vec[F_RESP] = proc_resp_load;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    mbox_setclr_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec[g]),
      .clr_i   (host_cmd_wr),
      .flush_i (soft_rst),
      .q_o     (flag_q[g])
    );
  end

  assign cmd_rdy  = flag_q[F_CMD];
  assign resp_rdy = flag_q[F_RESP];

  // Holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
    end else if (host_cmd_wr) begin
      cmd_word <= host_cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word <= '0;
    end else if (host_par_wr) begin
      par_word <= host_par_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qresp_word <= '0;
    end else if (proc_resp_load) begin
      qresp_word <= proc_resp_data;
    end
  end

  // Processor completion and error flags
  logic done_d;
  logic err_n_d;
  logic stat_en;

  always_comb begin
    stat_en = soft_rst | proc_flag_wr;
    done_d  = proc_done_val;
    err_n_d = proc_err_n_val;
    if (soft_rst) begin
      done_d  = 1'b0;
      err_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err_n <= 1'b1;
    end else if (stat_en) begin
      done  <= done_d;
      err_n <= err_n_d;
    end
  end

endmodule

// File: rtl/mbox_dev_fsm.sv
// Device-state tracking: reset, config init, self test, boot with timeout,
// passed and running, plus the sticky progress bits.
module mbox_dev_fsm
  import mbox_pkg::*;
#(
  parameter int BOOT_TIMEOUT = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       hw_init_ok,
  input  logic       cfg_done,
  input  logic       st_pass,
  input  logic       st_fail,
  input  logic       boot_ok,
  input  logic       init_done,
  output dev_state_e state_o,
  output logic       passed_o,
  output logic       ready_o,
  output logic       st_done_o,
  output logic       loaded_o,
  output logic       hw_ok_o
);

  localparam int TW = $clog2(BOOT_TIMEOUT + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(BOOT_TIMEOUT - 1);

  dev_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (soft_rst) begin
      state_d = ST_SOFT;
    end else begin
      case (state_q)
        ST_HARD, ST_SOFT: if (hw_init_ok) state_d = ST_CFG;
        ST_CFG:           if (cfg_done)   state_d = ST_TEST;
        ST_TEST: begin
          if (st_fail)      state_d = ST_FAIL;
          else if (st_pass) state_d = ST_BOOT;
        end
        ST_BOOT: begin
          if (boot_ok)               state_d = ST_PASS;
          else if (tmr_q == TMR_LAST) state_d = ST_IFAIL;
        end
        ST_PASS:          if (init_done)  state_d = ST_RUN;
        default:          state_d = state_q;
      endcase
    end
  end

  // Boot watchdog timer: runs only while booting
  always_comb begin
    tmr_en = (state_q == ST_BOOT) || (tmr_q != '0);
    tmr_d  = '0;
    if (state_q == ST_BOOT && state_d == ST_BOOT) begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HARD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  // Sticky progress bits
  logic st_set, ld_set;
  logic st_en, ld_en;

  always_comb begin
    st_set = (state_q == ST_TEST) && (state_d == ST_BOOT);
    ld_set = (state_q == ST_BOOT) && (state_d == ST_PASS);
    st_en  = st_set | soft_rst;
    ld_en  = ld_set | soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done_o <= 1'b0;
    end else if (st_en) begin
      st_done_o <= st_set & ~soft_rst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_o <= 1'b0;
    end else if (ld_en) begin
      loaded_o <= ld_set & ~soft_rst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_ok_o <= 1'b0;
    end else begin
      hw_ok_o <= hw_init_ok;
    end
  end

  assign state_o  = state_q;
  assign passed_o = (state_q == ST_PASS) || (state_q == ST_RUN);
  assign ready_o  = (state_q == ST_CFG)  || (state_q == ST_RUN);

endmodule

// File: rtl/mbox_fill_flags.sv
// Availability flags derived from the outbound queue fill count.
module mbox_fill_flags #(
  parameter int CNT_W       = 9,
  parameter int BLOCK_WORDS = 64
) (
  input  logic [CNT_W-1:0] q_count,
  output logic             data_rdy,
  output logic             blk_rdy
);

  localparam logic [CNT_W:0] BLK_LIM = (CNT_W+1)'(BLOCK_WORDS);

  always_comb begin
    data_rdy = (q_count != '0);
    blk_rdy  = ({1'b0, q_count} >= BLK_LIM);
  end

endmodule

// File: rtl/mbox_status_reg.sv
module mbox_status_reg
  import mbox_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CNT_W        = 9,
  parameter int BLOCK_WORDS  = 64,
  parameter int BOOT_TIMEOUT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_wr,
  input  logic [DATA_W-1:0] host_cmd_data,
  input  logic              host_par_wr,
  input  logic [DATA_W-1:0] host_par_data,
  input  logic              proc_cmd_rdy_set,
  input  logic              proc_resp_load,
  input  logic [DATA_W-1:0] proc_resp_data,
  input  logic              proc_flag_wr,
  input  logic              proc_done_val,
  input  logic              proc_err_n_val,
  input  logic              hw_init_ok,
  input  logic              cfg_done,
  input  logic              st_pass,
  input  logic              st_fail,
  input  logic              boot_ok,
  input  logic              init_done,
  input  logic              soft_rst,
  input  logic [CNT_W-1:0]  q_count,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] par_word,
  output logic [DATA_W-1:0] qresp_word,
  output logic [15:0]       status_word,
  output logic [3:0]        dev_state
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  logic       cmd_rdy, resp_rdy, done, err_n;
  logic       passed, ready, st_done, loaded, hw_ok;
  logic       data_rdy, blk_rdy;
  dev_state_e state;

  mbox_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk              (clk),
    .rst_n            (rst_i_n),
    .soft_rst         (soft_rst),
    .host_cmd_wr      (host_cmd_wr),
    .host_cmd_data    (host_cmd_data),
    .host_par_wr      (host_par_wr),
    .host_par_data    (host_par_data),
    .proc_cmd_rdy_set (proc_cmd_rdy_set),
    .proc_resp_load   (proc_resp_load),
    .proc_resp_data   (proc_resp_data),
    .proc_flag_wr     (proc_flag_wr),
    .proc_done_val    (proc_done_val),
    .proc_err_n_val   (proc_err_n_val),
    .cmd_word         (cmd_word),
    .par_word         (par_word),
    .qresp_word       (qresp_word),
    .cmd_rdy          (cmd_rdy),
    .resp_rdy         (resp_rdy),
    .done             (done),
    .err_n            (err_n)
  );

  mbox_dev_fsm #(.BOOT_TIMEOUT(BOOT_TIMEOUT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .soft_rst   (soft_rst),
    .hw_init_ok (hw_init_ok),
    .cfg_done   (cfg_done),
    .st_pass    (st_pass),
    .st_fail    (st_fail),
    .boot_ok    (boot_ok),
    .init_done  (init_done),
    .state_o    (state),
    .passed_o   (passed),
    .ready_o    (ready),
    .st_done_o  (st_done),
    .loaded_o   (loaded),
    .hw_ok_o    (hw_ok)
  );

  mbox_fill_flags #(.CNT_W(CNT_W), .BLOCK_WORDS(BLOCK_WORDS)) u_fill (
    .q_count  (q_count),
    .data_rdy (data_rdy),
    .blk_rdy  (blk_rdy)
  );

  // Status word assembly
  always_comb begin
    status_word             = '0;
    status_word[B_CMD_RDY]  = cmd_rdy;
    status_word[B_RESP_RDY] = resp_rdy;
    status_word[B_HW_OK]    = hw_ok;
    status_word[B_PASSED]   = passed;
    status_word[B_READY]    = ready;
    status_word[B_ERR_N]    = err_n;
    status_word[B_DONE]     = done;
    status_word[B_LOADED]   = loaded;
    status_word[B_ST_DONE]  = st_done;
    status_word[B_DATA_RDY] = data_rdy;
    status_word[B_BLK_RDY]  = blk_rdy;
  end

  assign dev_state = state;

endmodule

// File: rtl/mbox_status_chk.sv
module mbox_status_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cmd_wr,
  input logic [DATA_W-1:0] host_cmd_data,
  input logic              proc_cmd_rdy_set,
  input logic              proc_resp_load,
  input logic [DATA_W-1:0] proc_resp_data,
  input logic              soft_rst,
  input logic [CNT_W-1:0]  q_count,
  input logic [DATA_W-1:0] cmd_word,
  input logic [DATA_W-1:0] qresp_word,
  input logic [15:0]       status_word,
  input logic [3:0]        dev_state
);

  assert_cmd_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_wr |=> !status_word[B_CMD_RDY]);

  assert_cmd_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_cmd_rdy_set && !host_cmd_wr && !soft_rst) |=> status_word[B_CMD_RDY]);

  assert_resp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_resp_load && !host_cmd_wr && !soft_rst)
      |=> (status_word[B_RESP_RDY] && qresp_word == $past(proc_resp_data)));

  assert_cmd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_wr |=> (cmd_word == $past(host_cmd_data)));

  assert_empty_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> (!status_word[B_DATA_RDY] && !status_word[B_BLK_RDY]));

  assert_timeout_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == ST_IFAIL && $past(dev_state) != ST_IFAIL)
      |-> ($past(dev_state) == ST_BOOT));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dev_state == ST_SOFT && !status_word[B_ST_DONE]
                  && !status_word[B_LOADED] && !status_word[B_CMD_RDY]));

  assert_passed_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[B_PASSED]) |-> ($past(dev_state) == ST_BOOT));

  assert_ready_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_READY] |-> (dev_state == ST_CFG || dev_state == ST_RUN));

endmodule

bind mbox_status_reg mbox_status_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .host_cmd_wr      (host_cmd_wr),
  .host_cmd_data    (host_cmd_data),
  .proc_cmd_rdy_set (proc_cmd_rdy_set),
  .proc_resp_load   (proc_resp_load),
  .proc_resp_data   (proc_resp_data),
  .soft_rst         (soft_rst),
  .q_count          (q_count),
  .cmd_word         (cmd_word),
  .qresp_word       (qresp_word),
  .status_word      (status_word),
  .dev_state        (dev_state)
);

// File: tb/tb_mbox_status_reg.sv
`timescale 1ns/1ps
module tb_mbox_status_reg;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int BLK    = 16;
  localparam int TMO    = 20;

  logic              clk;
  logic              rst_n;
  logic              host_cmd_wr, host_par_wr;
  logic [DATA_W-1:0] host_cmd_data, host_par_data;
  logic              proc_cmd_rdy_set, proc_resp_load;
  logic [DATA_W-1:0] proc_resp_data;
  logic              proc_flag_wr, proc_done_val, proc_err_n_val;
  logic              hw_init_ok, cfg_done, st_pass, st_fail, boot_ok, init_done, soft_rst;
  logic [CNT_W-1:0]  q_count;
  logic [DATA_W-1:0] cmd_word, par_word, qresp_word;
  logic [15:0]       status_word;
  logic [3:0]        dev_state;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  mbox_status_reg #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BLOCK_WORDS(BLK), .BOOT_TIMEOUT(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .host_cmd_wr(host_cmd_wr), .host_cmd_data(host_cmd_data),
    .host_par_wr(host_par_wr), .host_par_data(host_par_data),
    .proc_cmd_rdy_set(proc_cmd_rdy_set), .proc_resp_load(proc_resp_load),
    .proc_resp_data(proc_resp_data), .proc_flag_wr(proc_flag_wr),
    .proc_done_val(proc_done_val), .proc_err_n_val(proc_err_n_val),
    .hw_init_ok(hw_init_ok), .cfg_done(cfg_done), .st_pass(st_pass),
    .st_fail(st_fail), .boot_ok(boot_ok), .init_done(init_done),
    .soft_rst(soft_rst), .q_count(q_count),
    .cmd_word(cmd_word), .par_word(par_word), .qresp_word(qresp_word),
    .status_word(status_word), .dev_state(dev_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one clock edge and land 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_pulses();
    host_cmd_wr = 0; host_par_wr = 0; proc_cmd_rdy_set = 0; proc_resp_load = 0;
    proc_flag_wr = 0; cfg_done = 0; st_pass = 0; st_fail = 0; boot_ok = 0;
    init_done = 0; soft_rst = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // {cmd_wr, rdy_set, resp_load, count[7:0], 1'b0, exp_cmd, exp_resp, exp_data, exp_blk}
  localparam logic [15:0] VEC [8] = '{
    {3'b010, 8'd0,   1'b0, 4'b1000},
    {3'b001, 8'd1,   1'b0, 4'b1110},
    {3'b100, 8'd15,  1'b0, 4'b0010},
    {3'b111, 8'd16,  1'b0, 4'b0011},
    {3'b010, 8'd17,  1'b0, 4'b1011},
    {3'b000, 8'd255, 1'b0, 4'b1011},
    {3'b001, 8'd0,   1'b0, 4'b1100},
    {3'b100, 8'd16,  1'b0, 4'b0011}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] last_resp;
    rst_n = 0;
    clear_pulses();
    host_cmd_data = '0; host_par_data = '0; proc_resp_data = '0;
    proc_done_val = 0; proc_err_n_val = 1; hw_init_ok = 0; q_count = '0;
    last_resp = '0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();

    // reset state
    check("R12 reset status", {16'h0, status_word}, 32'h0020);
    check("R6 reset state", {28'h0, dev_state}, 32'd0);
    check("R4 reset err_n", {31'h0, status_word[5]}, 32'd1);

    // handshake and fill-count vectors
    for (int i = 0; i < 8; i++) begin
      host_cmd_wr      = VEC[i][15];
      proc_cmd_rdy_set = VEC[i][14];
      proc_resp_load   = VEC[i][13];
      q_count          = VEC[i][12:5];
      host_cmd_data    = 32'h1000_0000 + i;
      proc_resp_data   = 32'hA500_0000 + i;
      if (VEC[i][13]) last_resp = 32'hA500_0000 + i;
      step();
      clear_pulses();
      check("R1 cmd ready", {31'h0, status_word[0]}, {31'h0, VEC[i][3]});
      check("R2 resp ready", {31'h0, status_word[1]}, {31'h0, VEC[i][2]});
      check("R5 data ready", {31'h0, status_word[9]}, {31'h0, VEC[i][1]});
      check("R5 block ready", {31'h0, status_word[10]}, {31'h0, VEC[i][0]});
      check("R2 resp word", qresp_word, last_resp);
      check("R12 pad bits", {27'h0, status_word[15:11]}, 32'h0);
    end
    q_count = '0;

    // R3 command and parameter capture
    host_cmd_wr = 1; host_cmd_data = 32'hCAFE_0001;
    host_par_wr = 1; host_par_data = 32'h0000_0BEE;
    step(); clear_pulses();
    check("R3 cmd word", cmd_word, 32'hCAFE_0001);
    check("R3 par word", par_word, 32'h0000_0BEE);

    // R4 done/err only on the strobe
    proc_flag_wr = 1; proc_done_val = 1; proc_err_n_val = 0;
    step(); clear_pulses();
    check("R4 done set", {31'h0, status_word[6]}, 32'd1);
    check("R4 err low", {31'h0, status_word[5]}, 32'd0);
    proc_done_val = 0; proc_err_n_val = 1;
    step(); step();
    check("R4 done ignored", {31'h0, status_word[6]}, 32'd1);
    check("R4 err ignored", {31'h0, status_word[5]}, 32'd0);

    // state walk
    hw_init_ok = 1;
    step();
    check("R6 cfg init", {28'h0, dev_state}, 32'd2);
    check("R10 ready in cfg", {31'h0, status_word[4]}, 32'd1);
    check("R9 passed in cfg", {31'h0, status_word[3]}, 32'd0);
    check("R11 hw ok", {31'h0, status_word[2]}, 32'd1);
    cfg_done = 1; step(); clear_pulses();
    check("R6 self test", {28'h0, dev_state}, 32'd3);
    check("R10 ready in test", {31'h0, status_word[4]}, 32'd0);
    st_pass = 1; step(); clear_pulses();
    check("R6 booting", {28'h0, dev_state}, 32'd4);
    check("R11 st done", {31'h0, status_word[8]}, 32'd1);
    boot_ok = 1; step(); clear_pulses();
    check("R6 passed", {28'h0, dev_state}, 32'd7);
    check("R9 passed bit", {31'h0, status_word[3]}, 32'd1);
    check("R10 ready in passed", {31'h0, status_word[4]}, 32'd0);
    check("R11 loaded", {31'h0, status_word[7]}, 32'd1);
    init_done = 1; step(); clear_pulses();
    check("R6 running", {28'h0, dev_state}, 32'd8);
    check("R10 ready in run", {31'h0, status_word[4]}, 32'd1);
    check("R9 passed in run", {31'h0, status_word[3]}, 32'd1);

    // R8 soft reset
    proc_cmd_rdy_set = 1; proc_resp_load = 1; step(); clear_pulses();
    soft_rst = 1; step(); clear_pulses();
    check("R8 soft state", {28'h0, dev_state}, 32'd1);
    check("R8 soft status", {16'h0, status_word & 16'h01FB}, 32'h0020);
    step();
    check("R6 soft to cfg", {28'h0, dev_state}, 32'd2);

    // failure path
    cfg_done = 1; step(); clear_pulses();
    st_fail = 1; st_pass = 1; step(); clear_pulses();
    check("R6 failed", {28'h0, dev_state}, 32'd5);
    st_pass = 1; boot_ok = 1; step(); clear_pulses();
    check("R6 failed holds", {28'h0, dev_state}, 32'd5);

    // R7 boot timeout
    soft_rst = 1; step(); clear_pulses();
    step();
    cfg_done = 1; step(); clear_pulses();
    st_pass = 1; step(); clear_pulses();
    check("R7 enter boot", {28'h0, dev_state}, 32'd4);
    repeat (TMO - 1) step();
    check("R7 still booting", {28'h0, dev_state}, 32'd4);
    step();
    check("R7 init failed", {28'h0, dev_state}, 32'd6);
    check("R9 passed after timeout", {31'h0, status_word[3]}, 32'd0);

    finish_run();
  end

endmodule